// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single PWM command into two gate enables for the upper and lower switches of a half-bridge. It keeps the two switches from conducting at the same time. Before it turns either switch on, it waits for digitized feedback that the opposite switch has actually gone off. A separate analog front end supplies three comparator flags: the lower gate is discharged, the switch node is low, and the upper gate-source voltage is discharged. All propagation and adaptive delays are clock-cycle counts set by parameters.

On a PWM rise, the controller first releases the lower gate after a turn-off delay. It then waits for the lower-gate-discharged flag and counts an adaptive delay before it raises the upper gate. On a PWM fall, it releases the upper gate after its own turn-off delay. Two timers then race to turn on the lower gate. One starts when the switch node is seen low. The other is a longer fallback that starts when the upper gate-source flag is seen. The fallback lets the lower switch turn on even when the switch node never drops, for example while the converter sinks current. An active-high enable forces both gates off at once and parks the controller in idle.

Top module: `hb_gate_sequencer`

## Requirements
- R1: While reset is asserted, and after reset until the enable rises, both gate outputs are low and `seq_state` reads 0 (idle).
- R2: While `enable` is low, both gate outputs are low in the same cycle, with no clock edge needed. PWM changes have no effect, and from the first clock edge with `enable` low, `seq_state` reads 0.
- R3: `hs_gate_en` and `ls_gate_en` are never high in the same cycle.
- R4: A PWM rise clears `ls_gate_en` exactly 2+T_LS_OFF clock edges after the first edge that samples the new level. Any PWM level held long enough settles with `hs_gate_en` equal to PWM and `ls_gate_en` its inverse.
- R5: `hs_gate_en` rises only after the synchronized lower-gate-discharged flag has been sampled in the state that waits for it, followed by T_HS_ADAPT cycles. With the flag following the lower gate, this is 3+T_HS_ADAPT edges after the lower gate falls.
- R6: A PWM fall clears `hs_gate_en` exactly 2+T_HS_OFF edges after the first edge that samples the new level.
- R7: When the synchronized switch-node-low flag is seen while the lower turn-on is pending, `ls_gate_en` rises T_LS_ADAPT cycles later. With the flag following the upper gate, this is 3+T_LS_ADAPT edges after the upper gate falls.
- R8: If the switch node never reads low, the upper gate-source-discharged flag starts a fallback timer, and `ls_gate_en` rises when it expires, 3+fallback edges after the upper gate falls. Whichever of the two timers expires first wins.
- R9: The fallback delay in use is the larger of T_LS_BACKUP and T_LS_ADAPT+1, so a fallback configured no longer than the normal delay is clamped.
- R10: A feedback flag is ignored unless it is sampled in the state that is waiting for it. A switch-node-low pulse that is gone before the upper gate is released does not shorten the lower turn-on.
- R11: If PWM reverses while a gate turn-on is still pending, that turn-on is abandoned: the gate never rises, and the sequence for the new level begins at its turn-off step.
- R12: If PWM reverses before a turn-off delay expires, the gate that was on is never released.
- R13: When `enable` rises, the controller applies the full sequence for the current PWM level. With PWM high and the lower-gate flag already set, `hs_gate_en` rises T_LS_OFF+1+T_HS_ADAPT edges after the first enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Output enable, active high; low forces both gates off |
| pwm | input | 1 | PWM command, asynchronous |
| ls_gate_low | input | 1 | Comparator flag: lower gate discharged |
| sw_node_low | input | 1 | Comparator flag: switch node below threshold |
| hs_vgs_low | input | 1 | Comparator flag: upper gate-source voltage discharged |
| hs_gate_en | output | 1 | Upper switch gate enable |
| ls_gate_en | output | 1 | Lower switch gate enable |
| seq_state | output | 3 | Sequencer state code, 0 = idle |

## Verification
The main instance uses turn-off delays of 3 and 2 cycles, adaptive delays of 4 and 3, and a fallback of 10. These values are distinct enough that each edge-to-edge latency points to a single path, and the 2-cycle upper turn-off leaves room for a switch-node pulse that lands entirely outside the waiting state. A second instance is built with a normal lower delay of 5 and a fallback of only 2, so the clamp to 6 shows up in its fallback latency. Each instance sees a small plant model in which each flag follows the opposite gate, with a switch that holds the switch node high.

// File: rtl/hbs_pkg.sv
`timescale 1ns/1ps
package hbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_LS_ON    = 3'd1,
    ST_LS_OFF   = 3'd2,
    ST_HS_WAIT  = 3'd3,
    ST_HS_ADAPT = 3'd4,
    ST_HS_ON    = 3'd5,
    ST_HS_OFF   = 3'd6,
    ST_LS_ARM   = 3'd7
  } seq_state_t;

  // A delay of zero cycles is treated as one cycle.
  function automatic int at_least_one(input int cycles);
    return (cycles < 1) ? 1 : cycles;
  endfunction

  // The fallback must outlast the normal lower turn-on delay.
  function automatic int fallback_cycles(input int backup, input int adapt);
    int a;
    a = at_least_one(adapt);
    return (backup > a) ? backup : a + 1;
  endfunction

endpackage

// File: rtl/hbs_sync.sv
`timescale 1ns/1ps
module hbs_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_async[b];
        stab_q <= meta_q;
      end
    end
    assign d_sync[b] = stab_q;
  end
endmodule

// File: rtl/hbs_timer.sv
`timescale 1ns/1ps
module hbs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [CW-1:0] last;

  assign last = limit - CW'(1);
  assign busy = run_q;
  assign done = run_q && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (clear) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q && (cnt_q != last)) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/hb_gate_sequencer.sv
`timescale 1ns/1ps
module hb_gate_sequencer
  import hbs_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int T_LS_OFF    = 3,
  parameter int T_HS_OFF    = 2,
  parameter int T_HS_ADAPT  = 4,
  parameter int T_LS_ADAPT  = 3,
  parameter int T_LS_BACKUP = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       pwm,
  input  logic       ls_gate_low,
  input  logic       sw_node_low,
  input  logic       hs_vgs_low,
  output logic       hs_gate_en,
  output logic       ls_gate_en,
  output logic [2:0] seq_state
);
  localparam logic [CNT_W-1:0] L_LS_OFF   = CNT_W'(at_least_one(T_LS_OFF));
  localparam logic [CNT_W-1:0] L_HS_OFF   = CNT_W'(at_least_one(T_HS_OFF));
  localparam logic [CNT_W-1:0] L_HS_ADAPT = CNT_W'(at_least_one(T_HS_ADAPT));
  localparam logic [CNT_W-1:0] L_LS_ADAPT = CNT_W'(at_least_one(T_LS_ADAPT));
  localparam logic [CNT_W-1:0] L_LS_FB    = CNT_W'(fallback_cycles(T_LS_BACKUP, T_LS_ADAPT));

  // Synchronized inputs: {vgs, sw, ldis, pwm}
  logic [3:0] raw_in, syn_in;
  logic       pwm_s, ldis_s, swl_s, vgs_s;

  assign raw_in = {hs_vgs_low, sw_node_low, ls_gate_low, pwm};

  hbs_sync #(.W(4)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_async(raw_in), .d_sync(syn_in)
  );
  assign pwm_s  = syn_in[0];
  assign ldis_s = syn_in[1];
  assign swl_s  = syn_in[2];
  assign vgs_s  = syn_in[3];

  seq_state_t st, nxt;
  logic hs_q, ls_q, hs_d, ls_d;

  // Named internal events
  logic step_start, step_clear, step_busy, step_done;
  logic main_start, main_clear, main_busy, main_done;
  logic fb_start, fb_clear, fb_busy, fb_done;
  logic lo_turn_on;
  logic [CNT_W-1:0] step_limit;

  function automatic logic is_timed(input seq_state_t s);
    return (s == ST_LS_OFF) || (s == ST_HS_OFF) || (s == ST_HS_ADAPT);
  endfunction

  assign lo_turn_on = main_done || fb_done;

  always_comb begin
    nxt  = st;
    hs_d = hs_q;
    ls_d = ls_q;
    if (!enable) begin
      nxt  = ST_IDLE;
      hs_d = 1'b0;
      ls_d = 1'b0;
    end else begin
      unique case (st)
        ST_IDLE:     nxt = pwm_s ? ST_LS_OFF : ST_HS_OFF;
        ST_LS_ON:    if (pwm_s) nxt = ST_LS_OFF;
        ST_LS_OFF: begin
          if (!pwm_s) nxt = ls_q ? ST_LS_ON : ST_HS_OFF;
          else if (step_done) begin
            nxt  = ST_HS_WAIT;
            ls_d = 1'b0;
          end
        end
        ST_HS_WAIT: begin
          if (!pwm_s) nxt = ST_HS_OFF;
          else if (ldis_s) nxt = ST_HS_ADAPT;
        end
        ST_HS_ADAPT: begin
          if (!pwm_s) nxt = ST_HS_OFF;
          else if (step_done) begin
            nxt  = ST_HS_ON;
            hs_d = 1'b1;
          end
        end
        ST_HS_ON:    if (!pwm_s) nxt = ST_HS_OFF;
        ST_HS_OFF: begin
          if (pwm_s) nxt = hs_q ? ST_HS_ON : ST_LS_OFF;
          else if (step_done) begin
            nxt  = ST_LS_ARM;
            hs_d = 1'b0;
          end
        end
        ST_LS_ARM: begin
          if (pwm_s) nxt = ST_LS_OFF;
          else if (lo_turn_on) begin
            nxt  = ST_LS_ON;
            ls_d = 1'b1;
          end
        end
        default:     nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      st   <= nxt;
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  // Single-delay timer shared by the turn-off and upper adaptive steps
  always_comb begin
    unique case (st)
      ST_LS_OFF:   step_limit = L_LS_OFF;
      ST_HS_OFF:   step_limit = L_HS_OFF;
      ST_HS_ADAPT: step_limit = L_HS_ADAPT;
      default:     step_limit = CNT_W'(1);
    endcase
  end
  assign step_start = (nxt != st) && is_timed(nxt);
  assign step_clear = (nxt != st);

  hbs_timer #(.CW(CNT_W)) step_tmr (
    .clk(clk), .rst_n(rst_n), .start(step_start), .clear(step_clear),
    .limit(step_limit), .busy(step_busy), .done(step_done)
  );

  // Two racing lower turn-on timers, armed only while waiting in ST_LS_ARM
  assign main_clear = (nxt != ST_LS_ARM);
  assign fb_clear   = (nxt != ST_LS_ARM);
  assign main_start = (st == ST_LS_ARM) && !main_clear && swl_s && !main_busy;
  assign fb_start   = (st == ST_LS_ARM) && !fb_clear && vgs_s && !fb_busy;

  hbs_timer #(.CW(CNT_W)) main_tmr (
    .clk(clk), .rst_n(rst_n), .start(main_start), .clear(main_clear),
    .limit(L_LS_ADAPT), .busy(main_busy), .done(main_done)
  );

  hbs_timer #(.CW(CNT_W)) fb_tmr (
    .clk(clk), .rst_n(rst_n), .start(fb_start), .clear(fb_clear),
    .limit(L_LS_FB), .busy(fb_busy), .done(fb_done)
  );

  assign hs_gate_en = hs_q && enable;
  assign ls_gate_en = ls_q && enable;
  assign seq_state  = st;

endmodule

// File: rtl/hbs_checker.sv
`timescale 1ns/1ps
module hbs_checker
  import hbs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       hs_en,
  input logic       ls_en,
  input seq_state_t st,
  input logic       step_busy,
  input logic       main_done,
  input logic       fb_done
);
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  assert_disabled_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!hs_en && !ls_en));

  assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st == ST_IDLE));

  assert_lo_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ls_en) && enable) |-> ($past(st) == ST_LS_OFF));

  assert_hs_on_after_adapt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(st) == ST_HS_ADAPT));

  assert_hs_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_en) && enable) |-> ($past(st) == ST_HS_OFF));

  assert_lo_on_by_timer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> ($past(st) == ST_LS_ARM && ($past(main_done) || $past(fb_done))));

  assert_step_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LS_OFF || st == ST_HS_OFF || st == ST_HS_ADAPT) |-> step_busy);
endmodule

bind hb_gate_sequencer hbs_checker chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .hs_en(hs_gate_en), .ls_en(ls_gate_en),
  .st(st), .step_busy(step_busy), .main_done(main_done), .fb_done(fb_done)
);

// File: tb/hb_gate_sequencer_tb_top.sv
`timescale 1ns/1ps
module hb_gate_sequencer_tb_top;
  localparam int TOL = 3, TOH = 2, TAH = 4, TAL = 3, TFB = 10;
  localparam int C_TAL = 5, C_TFB = 2;

  // Bench restatement of the clamp (R9)
  function automatic int exp_fallback(input int fb, input int al);
    return (fb >= al + 1) ? fb : al + 1;
  endfunction

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, en, pwm, sink, sw_man;
  logic [1:0] hs_v, ls_v;
  logic [2:0] st_i, st_c;
  logic ld_i, sw_i, vg_i, ld_c, sw_c, vg_c;

  // Plant: each flag follows the opposite gate; sink holds the switch node high
  assign ld_i = ~ls_v[0];
  assign vg_i = ~hs_v[0];
  assign sw_i = sink ? sw_man : ~hs_v[0];
  assign ld_c = ~ls_v[1];
  assign vg_c = ~hs_v[1];
  assign sw_c = sink ? sw_man : ~hs_v[1];

  hb_gate_sequencer #(.T_LS_OFF(TOL), .T_HS_OFF(TOH), .T_HS_ADAPT(TAH),
                      .T_LS_ADAPT(TAL), .T_LS_BACKUP(TFB)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(en), .pwm(pwm), .ls_gate_low(ld_i),
    .sw_node_low(sw_i), .hs_vgs_low(vg_i), .hs_gate_en(hs_v[0]),
    .ls_gate_en(ls_v[0]), .seq_state(st_i));

  hb_gate_sequencer #(.T_LS_OFF(TOL), .T_HS_OFF(TOH), .T_HS_ADAPT(TAH),
                      .T_LS_ADAPT(C_TAL), .T_LS_BACKUP(C_TFB)) dut_clamp (
    .clk(clk), .rst_n(rst_n), .enable(en), .pwm(pwm), .ls_gate_low(ld_c),
    .sw_node_low(sw_c), .hs_vgs_low(vg_c), .hs_gate_en(hs_v[1]),
    .ls_gate_en(ls_v[1]), .seq_state(st_c));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int hs_r[2], hs_f[2], ls_r[2], ls_f[2], n_hs_r[2], n_hs_f[2], n_ls_f[2];
  logic [1:0] hs_p = 2'b00, ls_p = 2'b00;
  int overlaps = 0;
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (hs_v[i] && !hs_p[i]) begin hs_r[i] = cyc; n_hs_r[i]++; end
      if (!hs_v[i] && hs_p[i]) begin hs_f[i] = cyc; n_hs_f[i]++; end
      if (ls_v[i] && !ls_p[i]) ls_r[i] = cyc;
      if (!ls_v[i] && ls_p[i]) begin ls_f[i] = cyc; n_ls_f[i]++; end
    end
    hs_p = hs_v;
    ls_p = ls_v;
    if (rst_n && (|(hs_v & ls_v))) overlaps++;
  end

  int checks = 0, errs = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    int k, nh, nf, hold;
    bit en_r;
    rst_n = 1'b0; en = 1'b0; pwm = 1'b0; sink = 1'b0; sw_man = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) tick();
    chk(hs_v == 2'b00 && ls_v == 2'b00, "R1 outputs in reset", {hs_v, ls_v}, 0);
    chk(st_i == 3'd0, "R1 state in reset", st_i, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(hs_v == 2'b00 && ls_v == 2'b00 && st_i == 3'd0, "R1 idle after reset", {hs_v, ls_v, st_i}, 0);

    // Enable with PWM low: lower gate settles on
    en = 1'b1;
    repeat (30) tick();
    chk(ls_v[0] && !hs_v[0], "R13 resume low level", {hs_v[0], ls_v[0]}, 1);

    // R4 / R5: PWM rise
    pwm = 1'b1; k = cyc + 1;
    for (int j = 0; j < 60 && !hs_v[0]; j++) tick();
    chk(ls_f[0] == k + 2 + TOL, "R4 lower release latency", ls_f[0], k + 2 + TOL);
    chk(hs_r[0] == ls_f[0] + 3 + TAH, "R5 upper turn-on latency", hs_r[0], ls_f[0] + 3 + TAH);

    // R6 / R7: PWM fall, switch node drops
    repeat (5) tick();
    pwm = 1'b0; k = cyc + 1;
    for (int j = 0; j < 60 && !ls_v[0]; j++) tick();
    chk(hs_f[0] == k + 2 + TOH, "R6 upper release latency", hs_f[0], k + 2 + TOH);
    chk(ls_r[0] == hs_f[0] + 3 + TAL, "R7 lower turn-on latency", ls_r[0], hs_f[0] + 3 + TAL);

    // R8 / R9: switch node never drops, fallback path
    repeat (5) tick();
    pwm = 1'b1;
    repeat (30) tick();
    sink = 1'b1; sw_man = 1'b0;
    pwm = 1'b0; k = cyc + 1;
    for (int j = 0; j < 80 && !(ls_v[0] && ls_v[1]); j++) tick();
    chk(ls_r[0] == hs_f[0] + 3 + TFB, "R8 fallback latency", ls_r[0], hs_f[0] + 3 + TFB);
    chk(ls_r[1] == hs_f[1] + 3 + exp_fallback(C_TFB, C_TAL), "R9 clamped fallback latency",
        ls_r[1], hs_f[1] + 3 + exp_fallback(C_TFB, C_TAL));

    // R10: switch-node pulse that ends before the wait state is ignored
    pwm = 1'b1;
    repeat (30) tick();
    pwm = 1'b0;
    tick();
    sw_man = 1'b1;
    tick();
    tick();
    sw_man = 1'b0;
    for (int j = 0; j < 80 && !ls_v[0]; j++) tick();
    chk(ls_r[0] == hs_f[0] + 3 + TFB, "R10 early flag ignored", ls_r[0], hs_f[0] + 3 + TFB);
    sink = 1'b0;
    repeat (10) tick();

    // R11: reversal while the upper turn-on is pending
    pwm = 1'b1;
    for (int j = 0; j < 60 && ls_v[0]; j++) tick();
    nh = n_hs_r[0];
    pwm = 1'b0;
    for (int j = 0; j < 60 && !ls_v[0]; j++) tick();
    chk(n_hs_r[0] == nh, "R11 abandoned upper turn-on", n_hs_r[0], nh);
    chk(ls_v[0] == 1'b1, "R11 lower gate restored", ls_v[0], 1);

    // R12: short glitches inside the turn-off delay
    repeat (20) tick();
    nf = n_ls_f[0];
    pwm = 1'b1; tick(); pwm = 1'b0;
    repeat (20) tick();
    chk(n_ls_f[0] == nf && ls_v[0], "R12 lower never released", n_ls_f[0], nf);
    pwm = 1'b1;
    repeat (30) tick();
    nf = n_hs_f[0];
    pwm = 1'b0; tick(); pwm = 1'b1;
    repeat (20) tick();
    chk(n_hs_f[0] == nf && hs_v[0], "R12 upper never released", n_hs_f[0], nf);

    // R2: disable forces both off and ignores PWM
    en = 1'b0;
    #1;
    chk(hs_v == 2'b00 && ls_v == 2'b00, "R2 immediate off", {hs_v, ls_v}, 0);
    for (int j = 0; j < 10; j++) begin
      pwm = 1'($urandom % 2);
      tick();
      chk(hs_v == 2'b00 && ls_v == 2'b00 && st_i == 3'd0, "R2 disabled", {hs_v, ls_v, st_i}, 0);
    end

    // R13: enable with PWM high applies the full rising sequence
    pwm = 1'b1;
    repeat (4) tick();
    en = 1'b1; k = cyc + 1;
    for (int j = 0; j < 60 && !hs_v[0]; j++) tick();
    chk(hs_r[0] == k + TOL + 1 + TAH, "R13 resume high level", hs_r[0], k + TOL + 1 + TAH);

    // Random phase: R3 and R4 settling
    for (int it = 0; it < 150; it++) begin
      hold = 1 + int'($urandom % 40);
      en_r = (($urandom % 8) != 0);
      sink = (($urandom % 4) == 0);
      pwm  = 1'($urandom % 2);
      en   = en_r;
      repeat (hold) tick();
      if (en_r && hold >= 25) begin
        chk(hs_v[0] == pwm && ls_v[0] == !pwm, "R4 settled outputs", {hs_v[0], ls_v[0]}, {pwm, !pwm});
        chk(hs_v[1] == pwm && ls_v[1] == !pwm, "R4 settled outputs clamp", {hs_v[1], ls_v[1]}, {pwm, !pwm});
      end
    end
    chk(overlaps == 0, "R3 overlap cycles", overlaps, 0);

    report();
    $finish;
  end
endmodule